// File: doc/BRIEF.md
# Iterative SHA-512 Family Hash Core

This block runs the SHA-512 compression function over one 1024-bit message block that has already been padded. One round is done per clock cycle. A single datapath serves all four members of the family. The only differences between them are the starting hash vector, which is chosen by a two-bit mode input, and how many leading bits of the 512-bit result are meaningful.

A host starts a new message with a one-cycle `init_i` pulse. The block then loads the starting vector for the selected mode and compresses the block on `block_i`. Each further block of the same message is chained with a `next_i` pulse, which compresses the current block on top of the hash left by the previous one. `ready_o` shows when a command can be accepted. `digest_valid_o` shows that `digest_o` holds a finished result.

Top module: `wide_hash_core`

## Requirements
- R1: A synchronous active-high reset, applied at any time including mid-block, leaves `ready_o`=1, `digest_valid_o`=0 and `digest_o`=0 after the clock edge.
- R2: Mode values select the variant: 0 = SHA-512/224, 1 = SHA-512/256, 2 = SHA-384, 3 = SHA-512. After an `init_i` the leading 224, 256, 384 or 512 bits of `digest_o` (from bit 511 downward) equal the standard digest for that variant. The remaining low bits are unspecified.
- R3: Message word 0 is taken from `block_i[1023:960]`, word 1 from the next 64 bits below it, and so on. The digest lists hash word 0 in `digest_o[511:448]`.
- R4: A command is accepted on a clock edge where `ready_o`=1 and `init_i` or `next_i` is 1. From that edge `ready_o` and `digest_valid_o` read 0. Exactly 81 cycles after that edge both read 1.
- R5: `next_i` compresses the current block starting from the present digest, so a two-block message yields the standard intermediate digest after the first block and the standard final digest after the second.
- R6: `mode_i` is used only when `init_i` is accepted. Its value during a `next_i` command has no effect on the result.
- R7: While `ready_o`=0, pulses on `init_i` or `next_i` and changes on `mode_i` or `block_i` have no effect on the result or on the latency.
- R8: `digest_o` does not change while a block is being processed, until the edge at which `ready_o` returns to 1.
- R9: If `init_i` and `next_i` are both 1 on an accepting edge, the command is treated as `init_i`.
- R10: While idle with no command, `digest_o`, `digest_valid_o` and `ready_o` hold their values, regardless of changes on `block_i` or `mode_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Start a new message with the current block |
| next_i | input | 1 | Chain the current block onto the running hash |
| mode_i | input | 2 | Variant select (0: 512/224, 1: 512/256, 2: 384, 3: 512) |
| block_i | input | 1024 | Padded message block, word 0 in the top bits |
| ready_o | output | 1 | High when a command can be accepted |
| digest_o | output | 512 | Hash words 0 to 7, word 0 in the top bits |
| digest_valid_o | output | 1 | High when `digest_o` holds a finished result |

## Verification
The bench builds the core with its default parameters: 80 rounds and a 16-word schedule window over 64-bit words. This makes the published single-block and two-block test messages directly comparable for every mode. These values also make the round constants that are computed at elaboration count toward the checked results, so an error in any constant, rotation or word ordering shows up as a digest mismatch. The latency count of 81 cycles follows from these same defaults.

// File: rtl/whc_pkg.sv
package whc_pkg;

  localparam int WORD_W    = 64;
  localparam int LANES     = 8;
  localparam int WIN_DEPTH = 16;
  localparam int BLOCK_W   = WIN_DEPTH * WORD_W;
  localparam int DIGEST_W  = LANES * WORD_W;

  typedef logic [WORD_W-1:0] word_t;
  // lane 0 sits in the most significant bits of the packed vector
  typedef logic [0:LANES-1][WORD_W-1:0] hstate_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FOLD} ctl_e;

  typedef enum logic [1:0] {
    MD_T224 = 2'd0,
    MD_T256 = 2'd1,
    MD_384  = 2'd2,
    MD_512  = 2'd3
  } mode_e;

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t sum_a(input word_t x);
    return rotr(x, 28) ^ rotr(x, 34) ^ rotr(x, 39);
  endfunction

  function automatic word_t sum_e(input word_t x);
    return rotr(x, 14) ^ rotr(x, 18) ^ rotr(x, 41);
  endfunction

  function automatic word_t mix_lo(input word_t x);
    return rotr(x, 1) ^ rotr(x, 8) ^ (x >> 7);
  endfunction

  function automatic word_t mix_hi(input word_t x);
    return rotr(x, 19) ^ rotr(x, 61) ^ (x >> 6);
  endfunction

  // index-th prime, counting 2 as index 0
  function automatic int nth_prime(input int index);
    int found;
    int res;
    bit is_p;
    found = 0;
    res   = 0;
    for (int c = 2; (res == 0) && (c < 4096); c++) begin
      is_p = 1'b1;
      for (int d = 2; d * d <= c; d++) begin
        if (c % d == 0) is_p = 1'b0;
      end
      if (is_p) begin
        if (found == index) res = c;
        found++;
      end
    end
    return res;
  endfunction

  // first 64 fraction bits of the cube root of p
  function automatic word_t cube_frac(input int p);
    logic [255:0] n;
    logic [255:0] r;
    logic [255:0] t;
    n = 256'(p) << 192;
    r = '0;
    for (int b = 66; b >= 0; b--) begin
      t = r | (256'(1) << b);
      if (t * t * t <= n) r = t;
    end
    return r[WORD_W-1:0];
  endfunction

  function automatic hstate_t mode_iv(input logic [1:0] m);
    hstate_t v;
    case (mode_e'(m))
      MD_T224: v = {64'h8C3D37C819544DA2, 64'h73E1996689DCD4D6,
                    64'h1DFAB7AE32FF9C82, 64'h679DD514582F9FCF,
                    64'h0F6D2B697BD44DA8, 64'h77E36F7304C48942,
                    64'h3F9D85A86A1D36C8, 64'h1112E6AD91D692A1};
      MD_T256: v = {64'h22312194FC2BF72C, 64'h9F555FA3C84C64C2,
                    64'h2393B86B6F53B151, 64'h963877195940EABD,
                    64'h96283EE2A88EFFE3, 64'hBE5E1E2553863992,
                    64'h2B0199FC2C85B8AA, 64'h0EB72DDC81C52CA2};
      MD_384:  v = {64'hCBBB9D5DC1059ED8, 64'h629A292A367CD507,
                    64'h9159015A3070DD17, 64'h152FECD8F70E5939,
                    64'h67332667FFC00B31, 64'h8EB44A8768581511,
                    64'hDB0C2E0D64F98FA7, 64'h47B5481DBEFA4FA4};
      default: v = {64'h6A09E667F3BCC908, 64'hBB67AE8584CAA73B,
                    64'h3C6EF372FE94F82B, 64'hA54FF53A5F1D36F1,
                    64'h510E527FADE682D1, 64'h9B05688C2B3E6C1F,
                    64'h1F83D9ABFB41BD6B, 64'h5BE0CD19137E2179};
    endcase
    return v;
  endfunction

endpackage

// File: rtl/whc_kconst.sv
module whc_kconst
  import whc_pkg::*;
#(
  parameter int NUM_ROUNDS = 80,
  parameter int IDX_W      = $clog2(NUM_ROUNDS)
) (
  input  logic [IDX_W-1:0] idx_i,
  output word_t            k_o
);

  word_t ktab [NUM_ROUNDS];

  // constants derived at elaboration from the cube roots of the first primes
  for (genvar gi = 0; gi < NUM_ROUNDS; gi++) begin : g_k
    localparam word_t KV = cube_frac(nth_prime(gi));
    assign ktab[gi] = KV;
  end

  assign k_o = ktab[idx_i];

endmodule

// File: rtl/whc_sched.sv
module whc_sched
  import whc_pkg::*;
#(
  parameter int DEPTH = WIN_DEPTH
) (
  input  logic                  clk,
  input  logic                  load_i,
  input  logic                  shift_i,
  input  logic [DEPTH*WORD_W-1:0] block_i,
  output word_t                 w_o
);

  word_t win_q [DEPTH];
  word_t fresh;

  // win_q[i] holds the word for the current round plus i
  assign fresh = mix_hi(win_q[DEPTH-2]) + win_q[DEPTH-7]
               + mix_lo(win_q[1]) + win_q[0];

  always_ff @(posedge clk) begin
    if (load_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        win_q[i] <= block_i[DEPTH*WORD_W-1-WORD_W*i -: WORD_W];
      end
    end else if (shift_i) begin
      for (int i = 0; i < DEPTH-1; i++) begin
        win_q[i] <= win_q[i+1];
      end
      win_q[DEPTH-1] <= fresh;
    end
  end

  assign w_o = win_q[0];

endmodule

// File: rtl/whc_round.sv
module whc_round
  import whc_pkg::*;
(
  input  hstate_t cur_i,
  input  word_t   k_i,
  input  word_t   w_i,
  output hstate_t nxt_o
);

  word_t tmp1, tmp2, choose, major;

  always_comb begin
    choose = (cur_i[4] & cur_i[5]) ^ (~cur_i[4] & cur_i[6]);
    major  = (cur_i[0] & cur_i[1]) ^ (cur_i[0] & cur_i[2]) ^ (cur_i[1] & cur_i[2]);
    tmp1   = cur_i[7] + sum_e(cur_i[4]) + choose + k_i + w_i;
    tmp2   = sum_a(cur_i[0]) + major;
    nxt_o[0] = tmp1 + tmp2;
    nxt_o[1] = cur_i[0];
    nxt_o[2] = cur_i[1];
    nxt_o[3] = cur_i[2];
    nxt_o[4] = cur_i[3] + tmp1;
    nxt_o[5] = cur_i[4];
    nxt_o[6] = cur_i[5];
    nxt_o[7] = cur_i[6];
  end

endmodule

// File: rtl/wide_hash_core.sv
module wide_hash_core
  import whc_pkg::*;
#(
  parameter int NUM_ROUNDS = 80
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                init_i,
  input  logic                next_i,
  input  logic [1:0]          mode_i,
  input  logic [BLOCK_W-1:0]  block_i,
  output logic                ready_o,
  output logic [DIGEST_W-1:0] digest_o,
  output logic                digest_valid_o
);

  localparam int               RND_W    = $clog2(NUM_ROUNDS);
  localparam logic [RND_W-1:0] LAST_RND = RND_W'(NUM_ROUNDS - 1);

  ctl_e             st_q;
  logic [RND_W-1:0] rnd_q;
  hstate_t          hash_q;
  hstate_t          work_q;
  hstate_t          round_nxt;
  logic             ready_q;
  logic             valid_q;
  logic             start;
  word_t            k_w;
  word_t            w_w;

  assign start = ready_q & (init_i | next_i);

  whc_kconst #(.NUM_ROUNDS(NUM_ROUNDS), .IDX_W(RND_W)) u_kconst (
    .idx_i (rnd_q),
    .k_o   (k_w)
  );

  whc_sched #(.DEPTH(WIN_DEPTH)) u_sched (
    .clk     (clk),
    .load_i  (start),
    .shift_i (st_q == ST_RUN),
    .block_i (block_i),
    .w_o     (w_w)
  );

  whc_round u_round (
    .cur_i (work_q),
    .k_i   (k_w),
    .w_i   (w_w),
    .nxt_o (round_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      rnd_q   <= '0;
      hash_q  <= '0;
      work_q  <= '0;
      ready_q <= 1'b1;
      valid_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            if (init_i) begin
              hash_q <= mode_iv(mode_i);
              work_q <= mode_iv(mode_i);
            end else begin
              work_q <= hash_q;
            end
            rnd_q   <= '0;
            ready_q <= 1'b0;
            valid_q <= 1'b0;
            st_q    <= ST_RUN;
          end
        end
        ST_RUN: begin
          work_q <= round_nxt;
          rnd_q  <= rnd_q + 1'b1;
          if (rnd_q == LAST_RND) st_q <= ST_FOLD;
        end
        ST_FOLD: begin
          for (int i = 0; i < LANES; i++) begin
            hash_q[i] <= hash_q[i] + work_q[i];
          end
          ready_q <= 1'b1;
          valid_q <= 1'b1;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o        = ready_q;
  assign digest_valid_o = valid_q;
  assign digest_o       = hash_q;

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ready_o && (init_i || next_i)) |=> (!ready_o && !digest_valid_o)); // R4

  AST_FOLD_FINISHES: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_FOLD) |=> (ready_o && digest_valid_o)); // R4

  AST_VALID_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
    digest_valid_o |-> ready_o); // R4

  AST_BUSY_STAYS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && rnd_q != LAST_RND) |=> !ready_o); // R7

  AST_BUSY_DIGEST_HELD: assert property (@(posedge clk) disable iff (rst)
    (!ready_o) |=> (ready_o || $stable(digest_o))); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !init_i && !next_i) |=>
      ($stable(digest_o) && ready_o && $stable(digest_valid_o))); // R10

endmodule

// File: tb/tb_wide_hash_core.sv
module tb_wide_hash_core;

  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          init_r = 1'b0;
  logic          next_r = 1'b0;
  logic [1:0]    mode_r = 2'd3;
  logic [1023:0] block_r = '0;
  logic          ready_w;
  logic [511:0]  digest_w;
  logic          valid_w;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wide_hash_core dut (
    .clk            (clk),
    .rst            (rst),
    .init_i         (init_r),
    .next_i         (next_r),
    .mode_i         (mode_r),
    .block_i        (block_r),
    .ready_o        (ready_w),
    .digest_o       (digest_w),
    .digest_valid_o (valid_w)
  );

  localparam logic [1023:0] ABC_BLK = {24'h616263, 8'h80, 864'h0, 128'h18};
  localparam logic [1023:0] TWO_B2  = {896'h0, 128'h380};

  localparam logic [511:0] ABC_512 = 512'hDDAF35A193617ABACC417349AE20413112E6FA4E89A97EA20A9EEEE64B55D39A2192992A274FC1A836BA3C23A3FEEBBD454D4423643CE80E2A9AC94FA54CA49F;
  localparam logic [511:0] ABC_384 = {384'hCB00753F45A35E8BB5A03D699AC65007272C32AB0EDED1631A8B605A43FF5BED8086072BA1E7CC2358BAECA134C825A7, 128'h0};
  localparam logic [511:0] ABC_256 = {256'h53048E2681941EF99B2E29B76B4C7DABE4C2D0C634FC6D46E0E2F13107E7AF23, 256'h0};
  localparam logic [511:0] ABC_224 = {224'h4634270F707B6A54DAAE7530460842E20E37ED265CEEE9A43E8924AA, 288'h0};
  localparam logic [511:0] TWO_512_MID = 512'h4319017A2B706E69CD4B05938BAE5E890186BF199F30AA956EF8B71D2F810585D787D6764B20BDA2A26014470973692000EC057F37D14B8E06ADD5B50E671C72;
  localparam logic [511:0] TWO_512_END = 512'h8E959B75DAE313DA8CF4F72814FC143F8F7779C6EB9F7FA17299AEADB6889018501D289E4900F7E4331B99DEC4B5433AC7D329EEB6DD26545E96E55B874BE909;
  localparam logic [511:0] TWO_384_MID = 512'h2A7F1D895FD58E0BEAAE96D1A673C741015A2173796C1A88F6352CA156ACAFF7C662113E9EBB4D6417B61A85E2CCF0A937EB9A6660FEB5198F2EBE9A81E6A2C5;
  localparam logic [511:0] TWO_384_END = {384'h09330C33F71147E83D192FC782CD1B4753111B173B3B05D22FA08086E3B0F712FCC7C71A557E2DB966C3E9FA91746039, 128'h0};

  function automatic logic [1023:0] two_blk1();
    logic [1023:0] b;
    b = '0;
    for (int j = 0; j < 14; j++) begin
      for (int k = 0; k < 8; k++) begin
        b[1023 - 8*(8*j + k) -: 8] = 8'h61 + 8'(j + k);
      end
    end
    b[1023 - 8*112 -: 8] = 8'h80;
    return b;
  endfunction

  function automatic logic [511:0] mode_mask(input logic [1:0] m);
    logic [511:0] msk;
    int bits;
    case (m)
      2'd0: bits = 224;
      2'd1: bits = 256;
      2'd2: bits = 384;
      default: bits = 512;
    endcase
    msk = '1;
    msk = msk << (512 - bits);
    return msk;
  endfunction

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // issue one command, wait for completion, return latency in cycles
  task automatic issue(input bit ini, input bit nxt, output int lat);
    @(negedge clk);
    init_r = ini;
    next_r = nxt;
    @(negedge clk);
    init_r = 1'b0;
    next_r = 1'b0;
    chk("R4 busy flags after accept", {510'h0, ready_w, valid_w}, 512'h0);
    lat = 0;
    while (!ready_w && lat < 300) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ready after reset", {511'h0, ready_w}, 512'h1);
    chk("R1 valid after reset", {511'h0, valid_w}, 512'h0);
    chk("R1 digest after reset", digest_w, 512'h0);
  endtask

  task automatic t_abc(input logic [1:0] m, input logic [511:0] exp, input string tag);
    int lat;
    mode_r  = m;
    block_r = ABC_BLK;
    issue(1'b1, 1'b0, lat);
    chk({"R4 latency ", tag}, 512'(lat), 512'd81);
    chk({"R4 valid at finish ", tag}, {511'h0, valid_w}, 512'h1);
    chk({"R2 R3 digest ", tag}, digest_w & mode_mask(m), exp);
  endtask

  task automatic t_two(input logic [1:0] m, input logic [1:0] m_next,
                       input logic [511:0] mid, input logic [511:0] fin, input string tag);
    int lat;
    mode_r  = m;
    block_r = two_blk1();
    issue(1'b1, 1'b0, lat);
    chk({"R5 intermediate ", tag}, digest_w, mid);
    mode_r  = m_next;  // R6: mode must not matter on a chained block
    block_r = TWO_B2;
    issue(1'b0, 1'b1, lat);
    chk({"R5 R4 chained latency ", tag}, 512'(lat), 512'd81);
    chk({"R5 R6 final ", tag}, digest_w & mode_mask(m), fin);
  endtask

  task automatic t_busy_ignore();
    int lat;
    mode_r  = 2'd3;
    block_r = ABC_BLK;
    @(negedge clk);
    init_r = 1'b1;
    @(negedge clk);
    init_r = 1'b0;
    lat = 0;
    repeat (20) begin @(negedge clk); lat++; end
    block_r = '1;
    mode_r  = 2'd0;
    init_r  = 1'b1;
    @(negedge clk); lat++;
    init_r = 1'b0;
    next_r = 1'b1;
    @(negedge clk); lat++;
    next_r = 1'b0;
    chk("R7 still busy after stray pulses", {511'h0, ready_w}, 512'h0);
    while (!ready_w && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    chk("R7 latency unchanged", 512'(lat), 512'd81);
    chk("R7 digest unaffected", digest_w, ABC_512);
  endtask

  task automatic t_priority();
    int lat;
    mode_r  = 2'd2;
    block_r = ABC_BLK;
    issue(1'b1, 1'b1, lat);
    chk("R9 init wins over next", digest_w & mode_mask(2'd2), ABC_384);
  endtask

  task automatic t_idle_hold();
    logic [511:0] snap;
    snap    = digest_w;
    block_r = '0;
    mode_r  = 2'd1;
    repeat (12) @(negedge clk);
    chk("R10 digest held while idle", digest_w, snap);
    chk("R10 flags held while idle", {510'h0, ready_w, valid_w}, 512'h3);
  endtask

  task automatic t_reset_midrun();
    mode_r  = 2'd3;
    block_r = ABC_BLK;
    @(negedge clk);
    init_r = 1'b1;
    @(negedge clk);
    init_r = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 ready after mid-run reset", {511'h0, ready_w}, 512'h1);
    chk("R1 valid after mid-run reset", {511'h0, valid_w}, 512'h0);
    chk("R1 digest after mid-run reset", digest_w, 512'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_abc(2'd3, ABC_512, "mode3");
    t_abc(2'd2, ABC_384, "mode2");
    t_abc(2'd1, ABC_256, "mode1");
    t_abc(2'd0, ABC_224, "mode0");
    t_two(2'd3, 2'd3, TWO_512_MID, TWO_512_END, "mode3");
    t_two(2'd2, 2'd3, TWO_384_MID, TWO_384_END, "mode2");
    t_busy_ignore();
    t_priority();
    t_idle_hold();
    t_reset_midrun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule